// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external 8K x 8 asynchronous static RAM. The host issues one read or one write at a time. The controller turns that request into a timed sequence of RAM strobes. The RAM has two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. The address and data are driven from registers, and the data bus is bidirectional through separate out, in and drive-enable signals. Every access runs through setup, strobe and hold phases. The length of each phase is a parameter in clock cycles, chosen as the ceiling of the RAM's nanosecond minimum divided by the clock period.

A read holds the output enable low for the read window and captures the RAM data on the last cycle of that window. It then returns the byte together with a one-cycle done pulse. A write drives the data bus from the setup phase through the hold phase. The write strobe is low only while both chip selects are already active. After every read, a turnaround phase keeps the controller's driver off while the RAM releases the bus. The host may present a new request only while ready is high.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, ready_o is 1 and done_o is 0. The RAM is deselected (sram_cs_n_o=1, sram_cs_o=0), sram_we_n_o=1, sram_oe_n_o=1 and sram_dq_oe_o=0.
- R2: A request (req_i=1) is taken only on a clock edge where ready_o is 1. ready_o falls in the next cycle. A request that is raised and dropped while busy leaves the RAM unchanged.
- R3: Both chip selects are active (sram_cs_n_o=0, sram_cs_o=1) exactly in the setup, strobe and hold phases. They are inactive whenever ready_o or done_o is 1.
- R4: For a read, sram_oe_n_o is 0 for exactly RD_CYC cycles. Those cycles start SETUP_CYC cycles after the accepting edge. sram_we_n_o stays 1, and the output enable is never low together with the write strobe.
- R5: For a read, done_o is 1 for one cycle, SETUP_CYC+RD_CYC+TURN_CYC cycles after the accepting edge. rdata_o then holds the byte the RAM drove on the last output-enable cycle.
- R6: For a write, sram_we_n_o is 0 for exactly WR_CYC cycles. Those cycles start SETUP_CYC cycles after the accepting edge. The write strobe is low only while both chip selects are active and sram_dq_o carries wdata_i.
- R7: sram_addr_o equals the accepted addr_i from the first setup cycle through the done cycle, and it never changes while the write strobe is low.
- R8: sram_dq_oe_o is never 1 while sram_oe_n_o is 0. After sram_oe_n_o rises, it stays 0 for at least TURN_CYC cycles.
- R9: After a write strobe ends, the chip selects, sram_addr_o, sram_dq_o and sram_dq_oe_o=1 are held for HOLD_CYC cycles.
- R10: For a write, done_o is 1 for one cycle, SETUP_CYC+WR_CYC+HOLD_CYC cycles after the accepting edge. ready_o is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, taken when ready_o is 1 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Host byte address |
| wdata_i | input | 8 | Host write data |
| ready_o | output | 1 | Controller idle, request may be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read data |
| sram_addr_o | output | 13 | RAM address bus |
| sram_cs_n_o | output | 1 | RAM chip select, active low |
| sram_cs_o | output | 1 | RAM chip select, active high |
| sram_we_n_o | output | 1 | RAM write strobe, active low |
| sram_oe_n_o | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 8 | Data driven toward the RAM |
| sram_dq_i | input | 8 | Data driven by the RAM |
| sram_dq_oe_o | output | 1 | Enables the controller's data driver |

## Verification
All results are counted from the accepting edge. The setup phase covers edges 1 to SETUP_CYC. The strobe covers the next RD_CYC or WR_CYC edges, followed by the hold or turnaround phase, and done_o rises one edge after the last of these. The bench holds a phase counter of its own that steps on each rising edge. On every falling edge it compares all outputs against the values that counter predicts, so each result is sampled in the cycle it is due. A behavioural RAM on the other side of the pins measures the length of each write strobe and checks address stability and bus ownership. It stores only writes that meet those checks.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  phase_e phase_i,
  input  logic   wr_i,
  output logic   ready_o,
  output logic   done_o,
  output logic   cs_n_o,
  output logic   cs_o,
  output logic   we_n_o,
  output logic   oe_n_o,
  output logic   dq_oe_o
);
  logic active, strobe;

  always_comb begin
    active  = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
    strobe  = (phase_i == PH_STROBE);
    ready_o = (phase_i == PH_IDLE);
    done_o  = (phase_i == PH_DONE);
    cs_n_o  = !active;
    cs_o    = active;
    we_n_o  = !(strobe && wr_i);
    oe_n_o  = !(strobe && !wr_i);
    dq_oe_o = active && wr_i;
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 4,
  parameter int WR_CYC    = 4,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_n_o,
  output logic              sram_cs_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);
  localparam int MAX_CYC = max2(max2(max2(SETUP_CYC, RD_CYC), max2(WR_CYC, HOLD_CYC)), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;
  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] L_RD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] L_WR    = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] L_TURN  = CNT_W'(TURN_CYC - 1);

  phase_e            phase_q, phase_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              expired;
  logic              accept;

  assign accept = (phase_q == PH_IDLE) && req_i;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE:   if (req_i) begin phase_d = PH_SETUP; load = 1'b1; load_val = L_SETUP; end
      PH_SETUP:  if (expired) begin
                   phase_d = PH_STROBE; load = 1'b1; load_val = wr_q ? L_WR : L_RD;
                 end
      PH_STROBE: if (expired) begin
                   // read: hold phase doubles as bus turnaround
                   phase_d = PH_HOLD; load = 1'b1; load_val = wr_q ? L_HOLD : L_TURN;
                 end
      PH_HOLD:   if (expired) phase_d = PH_DONE;
      PH_DONE:   phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        wr_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (phase_q == PH_STROBE && !wr_q && expired) rdata_q <= sram_dq_i;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  sram_pin_decode u_decode (
    .phase_i (phase_q),
    .wr_i    (wr_q),
    .ready_o (ready_o),
    .done_o  (done_o),
    .cs_n_o  (sram_cs_n_o),
    .cs_o    (sram_cs_o),
    .we_n_o  (sram_we_n_o),
    .oe_n_o  (sram_oe_n_o),
    .dq_oe_o (sram_dq_oe_o)
  );

  assign sram_addr_o = addr_q;
  assign sram_dq_o   = wdata_q;
  assign rdata_o     = rdata_q;

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_i |=> !ready_o);
  p_idle_deselect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o || done_o) |-> (sram_cs_n_o && !sram_cs_o));
  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_n_o && !sram_oe_n_o));
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));
  p_we_selected_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> (!sram_cs_n_o && sram_cs_o && sram_dq_oe_o));
  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o && $past(!sram_we_n_o)) |-> $stable(sram_addr_o));
  p_no_fight_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> !sram_dq_oe_o);
  p_turnaround_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sram_oe_n_o) |-> !sram_dq_oe_o);
  p_write_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (sram_dq_oe_o && !sram_cs_n_o && $stable(sram_addr_o)));
endmodule

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;
  localparam int S  = 1;
  localparam int RD = 4;
  localparam int WR = 4;
  localparam int H  = 1;
  localparam int T  = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, done;
  logic [7:0]  rdata;
  logic [12:0] s_addr;
  logic        s_cs_n, s_cs, s_we_n, s_oe_n, s_dq_oe;
  logic [7:0]  s_dq_o, s_dq_i, ram_q;
  logic        ram_drv;

  sram_strobe_ctrl #(.SETUP_CYC(S), .RD_CYC(RD), .WR_CYC(WR), .HOLD_CYC(H), .TURN_CYC(T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .sram_addr_o(s_addr),
    .sram_cs_n_o(s_cs_n), .sram_cs_o(s_cs), .sram_we_n_o(s_we_n), .sram_oe_n_o(s_oe_n),
    .sram_dq_o(s_dq_o), .sram_dq_i(s_dq_i), .sram_dq_oe_o(s_dq_oe));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  // behavioural RAM and host-side shadow
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  int wlow = 0, since_oe = 1000;
  logic [12:0] w_addr;
  logic [7:0]  w_dat;

  assign ram_drv = !s_cs_n && s_cs && !s_oe_n && s_we_n;
  assign s_dq_i  = ram_drv ? ram_q : 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      ram_q <= ram.exists(int'(s_addr)) ? ram[int'(s_addr)] : dflt(int'(s_addr));
      since_oe = !s_oe_n ? 0 : since_oe + 1;
      chk(!(s_dq_oe && ram_drv), "R8 bus contention", 32'(s_dq_oe), 0);
      if (s_dq_oe) chk(since_oe > T, "R8 turnaround", since_oe, T + 1);
      if (!s_cs_n && s_cs && !s_we_n) begin
        if (wlow > 0) chk(s_addr == w_addr, "R7 address moved in strobe", 32'(s_addr), 32'(w_addr));
        wlow++;
        w_addr = s_addr;
        w_dat  = s_dq_o;
      end else if (wlow > 0) begin
        chk(wlow >= WR, "R6 write strobe width", wlow, WR);
        if (wlow >= WR) ram[int'(w_addr)] = w_dat;
        wlow = 0;
      end
    end
  end

  // reference timeline: phase count since acceptance
  int ph = 0, plen = 0;
  bit m_wr = 1'b0;
  logic [12:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph = 0;
    else if (ph == 0) begin
      if (req) begin
        ph = 1; m_wr = we; m_addr = addr; m_wdata = wdata;
        plen = S + (we ? WR + H : RD + T) + 1;
        if (we) shadow[int'(addr)] = wdata;
      end
    end else if (ph == plen) ph = 0;
    else ph++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_sel, e_stb, e_done;
      int w;
      w      = m_wr ? WR : RD;
      e_sel  = (ph >= 1) && (ph <= S + w + (m_wr ? H : T));
      e_stb  = (ph > S) && (ph <= S + w);
      e_done = (ph != 0) && (ph == plen);
      chk(ready == (ph == 0), "R2 ready", 32'(ready), 32'(ph == 0));
      chk(done == e_done, m_wr ? "R10 done timing" : "R5 done timing", 32'(done), 32'(e_done));
      chk(s_cs_n == !e_sel && s_cs == e_sel, "R3 chip selects", {s_cs_n, s_cs}, {!e_sel, e_sel});
      chk(s_we_n == !(e_stb && m_wr), "R6 write strobe", 32'(s_we_n), 32'(!(e_stb && m_wr)));
      chk(s_oe_n == !(e_stb && !m_wr), "R4 output enable", 32'(s_oe_n), 32'(!(e_stb && !m_wr)));
      chk(s_dq_oe == (e_sel && m_wr), "R8 driver enable", 32'(s_dq_oe), 32'(e_sel && m_wr));
      if (ph != 0) chk(s_addr == m_addr, "R7 address", 32'(s_addr), 32'(m_addr));
      if (e_sel && m_wr)
        chk(s_dq_o == m_wdata, (ph > S + w) ? "R9 data hold" : "R6 write data", 32'(s_dq_o), 32'(m_wdata));
      if (e_done && !m_wr) begin
        logic [7:0] e_rd;
        e_rd = shadow.exists(int'(m_addr)) ? shadow[int'(m_addr)] : dflt(int'(m_addr));
        chk(rdata == e_rd, "R5 read data", 32'(rdata), 32'(e_rd));
      end
    end
  end

  task automatic reset_pins_chk(input string tag);
    chk(ready && !done && s_cs_n && !s_cs && s_we_n && s_oe_n && !s_dq_oe, tag,
        {ready, done, s_cs_n, s_cs, s_we_n, s_oe_n, s_dq_oe}, 7'b1010110);
  endtask

  task automatic do_op(input bit w, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_pins_chk("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    reset_pins_chk("R1 after reset");

    do_op(1'b1, 13'h0000, 8'hA5);
    do_op(1'b1, 13'h1FFF, 8'h3C);
    do_op(1'b1, 13'h0ABC, 8'h7E);
    do_op(1'b0, 13'h0000, 8'h00);
    do_op(1'b0, 13'h1FFF, 8'h00);
    do_op(1'b0, 13'h0ABC, 8'h00);
    do_op(1'b0, 13'h0555, 8'h00);   // never written
    // read directly followed by write: turnaround (R8)
    do_op(1'b0, 13'h0ABC, 8'h00);
    do_op(1'b1, 13'h0ABC, 8'hC3);
    do_op(1'b0, 13'h0ABC, 8'h00);

    // R2: request raised and dropped while busy is not taken
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 13'h0100; wdata = 8'h11;
    @(negedge clk);
    addr = 13'h0200; wdata = 8'h99;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    do_op(1'b0, 13'h0200, 8'h00);
    do_op(1'b0, 13'h0100, 8'h00);

    for (int i = 0; i < 8; i++) do_op(1'b1, 13'(i * 1000 + 7), 8'(i * 37 + 1));
    for (int i = 7; i >= 0; i--) do_op(1'b0, 13'(i * 1000 + 7), 8'h00);
    do_op(1'b1, 13'h0000, 8'h5A);
    do_op(1'b0, 13'h0000, 8'h00);

    repeat (3) @(negedge clk);
    reset_pins_chk("R1 idle after traffic");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule